// File: doc/BRIEF.md
# Indirect Transfer Edge Validation Cache

This block sits at the commit stage and decides if a retiring indirect jump, call or return may complete. Each such instruction presents its source address and its target address. The block looks up that pair in a small set-associative cache of edges that were already validated. It also checks the target against a table of approved target regions. If either one approves the transfer, the instruction retires. If neither does, the block squashes the instruction and sends fetch to a fixed software validation routine. The block also hands that routine the pair that failed.

When the routine accepts the edge, it writes the pair back through the fill port, and later transfers along that edge retire at once. The region table is written through its own write port. A flush input clears every learned edge in a single cycle. The region table stays as it is.

Top module: `edge_gate_cache`

## Requirements
- R1: For each cycle with `chk_valid` high, the next cycle carries exactly one one-cycle response, either `retire_ok` or `squash`. A cycle without `chk_valid` gives no response in the following cycle.
- R2: A lookup whose source and target both equal those of a valid stored edge retires. A lookup that differs in the source alone, or in the target alone, gets no approval from that edge.
- R3: A lookup retires, whatever its source, when its target satisfies base <= target < limit for a valid region entry. The limit itself is excluded. Entries are written with `rng_wr_en`, and an entry written with `rng_wr_valid` = 0 stops approving.
- R4: A lookup approved by neither the edges nor the regions raises `squash`. In the same cycle, `redirect_pc` equals the routine address (default 32'h0000_F000), and `miss_src`/`miss_tgt` equal the rejected pair. `redirect_pc` is zero when `squash` is low.
- R5: The set of a pair is src[ALIGN+IW-1:ALIGN] XOR tgt[ALIGN+IW-1:ALIGN] (ALIGN = 2, IW = 4 by default). Each set holds four edges, and a fill uses a free way before it replaces anything.
- R6: In a full set, a fill replaces the least recently used edge. Both lookup hits and fills count as uses.
- R7: A fill of a pair that is already stored is ignored. It stores nothing and does not change the replacement order.
- R8: A lookup in the same cycle as a fill to the same set sees the set as it was before the fill.
- R9: `flush` invalidates all edges in one cycle and leaves the region table unchanged. A fill in the same cycle as `flush` is dropped.
- R10: After reset, no edge and no region is valid, and `retire_ok`, `squash` and `redirect_pc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A retiring indirect transfer is presented |
| chk_src | input | AW (32) | Source address of the transfer |
| chk_tgt | input | AW (32) | Target address of the transfer |
| fill_valid | input | 1 | Validation routine installs an edge |
| fill_src | input | AW (32) | Source address of the installed edge |
| fill_tgt | input | AW (32) | Target address of the installed edge |
| flush | input | 1 | Invalidate all stored edges |
| rng_wr_en | input | 1 | Write one region entry |
| rng_wr_idx | input | RW (3) | Region entry index |
| rng_wr_valid | input | 1 | Valid bit written to the entry |
| rng_wr_base | input | AW (32) | Inclusive lower bound |
| rng_wr_limit | input | AW (32) | Exclusive upper bound |
| retire_ok | output | 1 | Transfer approved, may retire |
| squash | output | 1 | Transfer rejected, squash it |
| redirect_pc | output | AW (32) | Fetch redirect address, valid with squash |
| miss_src | output | AW (32) | Source of the rejected transfer |
| miss_tgt | output | AW (32) | Target of the rejected transfer |

## Verification
A lookup and a fill can land in the same cycle and the same set, and a fill can also coincide with a flush. The bench drives a lookup and a fill of one identical pair on the same clock edge and requires a squash. A lookup of that pair one cycle later must then retire. It also raises flush together with a fill and requires the filled pair to miss afterwards. The replacement order that results from mixed hits, fills and ignored duplicate fills is judged by which earlier edges still retire.

// File: rtl/egc_pkg.sv
package egc_pkg;
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_EDGE  = 2'd1,
    VERD_RANGE = 2'd2,
    VERD_MISS  = 2'd3
  } verdict_e;
endpackage

// File: rtl/egc_range_table.sv
module egc_range_table #(
  parameter int AW     = 32,
  parameter int RANGES = 8,
  localparam int RW    = $clog2(RANGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_base,
  input  logic [AW-1:0] wr_limit,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  logic [RANGES-1:0] hit_vec;

  for (genvar g = 0; g < RANGES; g++) begin : g_ent
    logic          vld_q, vld_d, sel;
    logic [AW-1:0] base_q, limit_q;

    assign sel = wr_en && (wr_idx == RW'(g));

    always_comb begin
      vld_d = vld_q;
      if (sel) vld_d = wr_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        base_q  <= wr_base;
        limit_q <= wr_limit;
      end
    end

    assign hit_vec[g] = vld_q && (probe_addr >= base_q) && (probe_addr < limit_q);
  end

  assign probe_hit = |hit_vec;
endmodule

// File: rtl/egc_lru_set.sv
module egc_lru_set #(
  parameter int WAYS = 4,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic [WW-1:0] a_way,
  input  logic          b_en,
  input  logic [WW-1:0] b_way,
  output logic [WW-1:0] victim
);
  typedef logic [WAYS-1:0][WW-1:0] age_t;

  age_t age_q, age_d, age_mid;

  // Mark way w as most recent; every way that was younger ages by one.
  function automatic age_t touch(input age_t a, input logic [WW-1:0] w);
    age_t r;
    r = a;
    for (int i = 0; i < WAYS; i++) begin
      if (a[i] < a[w]) r[i] = a[i] + 1'b1;
    end
    r[w] = '0;
    return r;
  endfunction

  always_comb begin
    age_mid = a_en ? touch(age_q, a_way) : age_q;
    age_d   = b_en ? touch(age_mid, b_way) : age_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= WW'(w);
    end else if (a_en || b_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[w] == WW'(WAYS - 1)) victim = WW'(w);
    end
  end
endmodule

// File: rtl/egc_edge_array.sv
module egc_edge_array #(
  parameter int AW    = 32,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int ALIGN = 2,
  localparam int IW   = $clog2(SETS),
  localparam int WW   = $clog2(WAYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_en,
  input  logic [AW-1:0]            lk_src,
  input  logic [AW-1:0]            lk_tgt,
  output logic                     lk_hit,
  output logic [IW-1:0]            lk_set,
  output logic [WW-1:0]            lk_way,
  input  logic                     fill_en,
  input  logic [AW-1:0]            fill_src,
  input  logic [AW-1:0]            fill_tgt,
  input  logic                     flush,
  input  logic [SETS-1:0][WW-1:0]  victim_way,
  output logic                     fill_do,
  output logic [IW-1:0]            fill_set,
  output logic [WW-1:0]            fill_way
);
  logic [AW-1:0]                 src_q [SETS][WAYS];
  logic [AW-1:0]                 tgt_q [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]     vld_q, vld_d;
  logic [WAYS-1:0]               lk_match, fl_match, fl_free;
  logic                          fill_dup, have_free;
  logic [WW-1:0]                 free_way;

  function automatic logic [IW-1:0] set_of(input logic [AW-1:0] s, input logic [AW-1:0] t);
    return s[ALIGN +: IW] ^ t[ALIGN +: IW];
  endfunction

  assign lk_set   = set_of(lk_src, lk_tgt);
  assign fill_set = set_of(fill_src, fill_tgt);

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_set][w] && (src_q[lk_set][w] == lk_src) &&
                    (tgt_q[lk_set][w] == lk_tgt);
      if (lk_match[w]) lk_way = WW'(w);
    end
    lk_hit = lk_en && (|lk_match);
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      fl_match[w] = vld_q[fill_set][w] && (src_q[fill_set][w] == fill_src) &&
                    (tgt_q[fill_set][w] == fill_tgt);
      fl_free[w]  = !vld_q[fill_set][w];
      if (fl_free[w]) free_way = WW'(w);
    end
    fill_dup  = |fl_match;
    have_free = |fl_free;
    fill_way  = have_free ? free_way : victim_way[fill_set];
    fill_do   = fill_en && !flush && !fill_dup;
  end

  always_comb begin
    vld_d = vld_q;
    if (flush) vld_d = '0;
    else if (fill_do) vld_d[fill_set][fill_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      src_q[fill_set][fill_way] <= fill_src;
      tgt_q[fill_set][fill_way] <= fill_tgt;
    end
  end
endmodule

// File: rtl/edge_gate_cache.sv
module edge_gate_cache #(
  parameter int          AW      = 32,
  parameter int          SETS    = 16,
  parameter int          WAYS    = 4,
  parameter int          RANGES  = 8,
  parameter int          ALIGN   = 2,
  parameter logic [31:0] SLED_PC = 32'h0000_F000,
  localparam int         IW      = $clog2(SETS),
  localparam int         WW      = $clog2(WAYS),
  localparam int         RW      = $clog2(RANGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_src,
  input  logic [AW-1:0] chk_tgt,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_src,
  input  logic [AW-1:0] fill_tgt,
  input  logic          flush,
  input  logic          rng_wr_en,
  input  logic [RW-1:0] rng_wr_idx,
  input  logic          rng_wr_valid,
  input  logic [AW-1:0] rng_wr_base,
  input  logic [AW-1:0] rng_wr_limit,
  output logic          retire_ok,
  output logic          squash,
  output logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] miss_src,
  output logic [AW-1:0] miss_tgt
);
  import egc_pkg::*;

  logic                    edge_hit, range_hit, fill_do;
  logic [IW-1:0]           lk_set, fill_set;
  logic [WW-1:0]           lk_way, fill_way;
  logic [SETS-1:0][WW-1:0] victim_way;
  verdict_e                verd;
  logic                    retire_d, squash_d, retire_q, squash_q;
  logic [AW-1:0]           miss_src_q, miss_tgt_q;

  egc_edge_array #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .ALIGN(ALIGN)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .lk_en(chk_valid), .lk_src(chk_src), .lk_tgt(chk_tgt),
    .lk_hit(edge_hit), .lk_set(lk_set), .lk_way(lk_way),
    .fill_en(fill_valid), .fill_src(fill_src), .fill_tgt(fill_tgt),
    .flush(flush), .victim_way(victim_way),
    .fill_do(fill_do), .fill_set(fill_set), .fill_way(fill_way)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_lru
    egc_lru_set #(.WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .a_en(edge_hit && (lk_set == IW'(s))), .a_way(lk_way),
      .b_en(fill_do && (fill_set == IW'(s))), .b_way(fill_way),
      .victim(victim_way[s])
    );
  end

  egc_range_table #(.AW(AW), .RANGES(RANGES)) u_ranges (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rng_wr_en), .wr_idx(rng_wr_idx), .wr_valid(rng_wr_valid),
    .wr_base(rng_wr_base), .wr_limit(rng_wr_limit),
    .probe_addr(chk_tgt), .probe_hit(range_hit)
  );

  always_comb begin
    if (!chk_valid)     verd = VERD_NONE;
    else if (edge_hit)  verd = VERD_EDGE;
    else if (range_hit) verd = VERD_RANGE;
    else                verd = VERD_MISS;
    retire_d = (verd == VERD_EDGE) || (verd == VERD_RANGE);
    squash_d = (verd == VERD_MISS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire_q <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      retire_q <= retire_d;
      squash_q <= squash_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_src_q <= '0;
      miss_tgt_q <= '0;
    end else if (squash_d) begin
      miss_src_q <= chk_src;
      miss_tgt_q <= chk_tgt;
    end
  end

  assign retire_ok   = retire_q;
  assign squash      = squash_q;
  assign redirect_pc = squash_q ? AW'(SLED_PC) : '0;
  assign miss_src    = miss_src_q;
  assign miss_tgt    = miss_tgt_q;
endmodule

// File: rtl/egc_checker.sv
module egc_checker #(
  parameter int          AW      = 32,
  parameter logic [31:0] SLED_PC = 32'h0000_F000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_valid,
  input logic [AW-1:0] chk_src,
  input logic [AW-1:0] chk_tgt,
  input logic          fill_valid,
  input logic [AW-1:0] fill_src,
  input logic [AW-1:0] fill_tgt,
  input logic          flush,
  input logic          retire_ok,
  input logic          squash,
  input logic [AW-1:0] redirect_pc,
  input logic [AW-1:0] miss_src,
  input logic [AW-1:0] miss_tgt
);
  p_one_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> (retire_ok != squash));

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> (!retire_ok && !squash));

  p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (redirect_pc == AW'(SLED_PC)));

  p_no_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !squash |-> (redirect_pc == '0));

  p_miss_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (miss_src == $past(chk_src) && miss_tgt == $past(chk_tgt)));

  p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && $past(fill_valid && !flush) && chk_src == $past(fill_src) &&
     chk_tgt == $past(fill_tgt)) |=> retire_ok);
endmodule

bind edge_gate_cache egc_checker #(.AW(AW), .SLED_PC(SLED_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_src(chk_src),
  .chk_tgt(chk_tgt), .fill_valid(fill_valid), .fill_src(fill_src),
  .fill_tgt(fill_tgt), .flush(flush), .retire_ok(retire_ok), .squash(squash),
  .redirect_pc(redirect_pc), .miss_src(miss_src), .miss_tgt(miss_tgt)
);

// File: tb/sim_edge_gate_cache.sv
`timescale 1ns/1ps
module sim_edge_gate_cache;
  localparam logic [31:0] SLED = 32'h0000_F000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid = 0, fill_valid = 0, flush = 0;
  logic [31:0] chk_src = 0, chk_tgt = 0, fill_src = 0, fill_tgt = 0;
  logic        rng_wr_en = 0, rng_wr_valid = 0;
  logic [2:0]  rng_wr_idx = 0;
  logic [31:0] rng_wr_base = 0, rng_wr_limit = 0;
  logic        retire_ok, squash;
  logic [31:0] redirect_pc, miss_src, miss_tgt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  edge_gate_cache u0 (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_src(chk_src),
    .chk_tgt(chk_tgt), .fill_valid(fill_valid), .fill_src(fill_src),
    .fill_tgt(fill_tgt), .flush(flush), .rng_wr_en(rng_wr_en),
    .rng_wr_idx(rng_wr_idx), .rng_wr_valid(rng_wr_valid),
    .rng_wr_base(rng_wr_base), .rng_wr_limit(rng_wr_limit),
    .retire_ok(retire_ok), .squash(squash), .redirect_pc(redirect_pc),
    .miss_src(miss_src), .miss_tgt(miss_tgt)
  );

  // op(1: fill, 0: lookup) | src | tgt | expected retire
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 32'h0000_0400, 32'h0000_0804, 1'b0},
    {1'b1, 32'h0000_0400, 32'h0000_0804, 1'b0},
    {1'b0, 32'h0000_0400, 32'h0000_0804, 1'b1},
    {1'b0, 32'h0000_0400, 32'h0000_0808, 1'b0},
    {1'b0, 32'h0000_0404, 32'h0000_0804, 1'b0},
    {1'b1, 32'h0000_003C, 32'h1234_5670, 1'b0},
    {1'b0, 32'h0000_003C, 32'h1234_5670, 1'b1},
    {1'b0, 32'h0000_0400, 32'h0000_0804, 1'b1}
  };

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] s, input logic [31:0] t);
    fill_valid = 1; fill_src = s; fill_tgt = t;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_look(input string req, input logic [31:0] s, input logic [31:0] t,
                         input bit exp_ret);
    chk_valid = 1; chk_src = s; chk_tgt = t;
    @(negedge clk);
    chk_valid = 0;
    cmp({req, " retire"}, 64'(retire_ok), 64'(exp_ret));
    cmp({req, " squash"}, 64'(squash), 64'(!exp_ret));
    if (!exp_ret) begin
      cmp({req, " redirect R4"}, 64'(redirect_pc), 64'(SLED));
      cmp({req, " miss pair R4"}, {miss_src, miss_tgt}, {s, t});
    end
  endtask

  task automatic do_range(input logic [2:0] idx, input bit v, input logic [31:0] b,
                          input logic [31:0] l);
    rng_wr_en = 1; rng_wr_idx = idx; rng_wr_valid = v; rng_wr_base = b; rng_wr_limit = l;
    @(negedge clk);
    rng_wr_en = 0;
  endtask

  task automatic do_flush();
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: outputs low while in reset
    cmp("R10 reset retire", 64'(retire_ok), 64'd0);
    cmp("R10 reset squash", 64'(squash), 64'd0);
    cmp("R10 reset redirect", 64'(redirect_pc), 64'd0);
    rst_n = 1;
    @(negedge clk);
    // R10: nothing stored after reset, no region approves
    do_look("R10 empty", 32'h0000_1000, 32'h0000_2000, 0);
    do_look("R10 empty range", 32'h0000_0000, 32'h0000_8000, 0);
    // R1: idle cycle produces no response
    @(negedge clk);
    cmp("R1 idle retire", 64'(retire_ok), 64'd0);
    cmp("R1 idle squash", 64'(squash), 64'd0);

    // R2 / R1 table walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][65]) do_fill(VEC[i][64:33], VEC[i][32:1]);
      else            do_look("R2 table", VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
    end

    // R5, R7, R6 in set 0 (src 0x1000, targets differ above bit 5)
    do_flush();
    do_fill(32'h1000, 32'h2000);   // A
    do_fill(32'h1000, 32'h2040);   // B
    do_fill(32'h1000, 32'h2080);   // C
    do_fill(32'h1000, 32'h20C0);   // D
    do_look("R5 four ways", 32'h1000, 32'h20C0, 1);
    do_fill(32'h1000, 32'h2000);   // duplicate A: no effect
    do_fill(32'h1000, 32'h2100);   // E replaces A
    do_look("R7 dup no touch", 32'h1000, 32'h2000, 0);
    do_look("R7 B kept", 32'h1000, 32'h2040, 1);
    do_fill(32'h1000, 32'h2140);   // F replaces C (B was just used)
    do_look("R6 lru victim", 32'h1000, 32'h2080, 0);
    do_look("R6 hit kept", 32'h1000, 32'h2040, 1);
    do_look("R6 fill kept", 32'h1000, 32'h2140, 1);

    // R3 regions
    do_range(3'd5, 1, 32'h0000_8000, 32'h0000_9000);
    do_look("R3 base", 32'h0000_0010, 32'h0000_8000, 1);
    do_look("R3 top", 32'h0000_0FF0, 32'h0000_8FFC, 1);
    do_look("R3 limit", 32'h0000_0010, 32'h0000_9000, 0);
    do_look("R3 below", 32'h0000_0010, 32'h0000_7FFC, 0);

    // R9 flush clears edges, keeps regions
    do_flush();
    do_look("R9 edge gone", 32'h1000, 32'h2040, 0);
    do_look("R9 range kept", 32'h0000_0020, 32'h0000_8800, 1);
    // R9 fill during flush dropped
    flush = 1; fill_valid = 1; fill_src = 32'h1000; fill_tgt = 32'h2000;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    do_look("R9 fill dropped", 32'h1000, 32'h2000, 0);

    // R8 lookup and fill of the same pair in one cycle
    chk_valid = 1; chk_src = 32'h1000; chk_tgt = 32'h2000;
    fill_valid = 1; fill_src = 32'h1000; fill_tgt = 32'h2000;
    @(negedge clk);
    chk_valid = 0; fill_valid = 0;
    cmp("R8 pre-fill view squash", 64'(squash), 64'd1);
    cmp("R8 pre-fill view retire", 64'(retire_ok), 64'd0);
    do_look("R8 after fill", 32'h1000, 32'h2000, 1);

    // R3 region disabled
    do_range(3'd5, 0, 32'h0000_8000, 32'h0000_9000);
    do_look("R3 disabled", 32'h0000_0010, 32'h0000_8000, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule